// File: doc/BRIEF.md
# Network Controller Interrupt Status Register Set

This block holds the interrupt cause bits of a network controller. Single-cycle event pulses from the transmit path, receive path, DMA engines, statistics counters, link monitor and host-request logic each set a latched status bit. The latched bits are gated by an enable mask, and the OR of the gated bits drives one level interrupt line. Each cause bit is cleared by the mechanism that owns it: a write of 1 by the host, a strobe from the logic that serviced the event, or a DMA reset.

The host reaches the block through a simple register port with 16-bit data and a registered read result. The port offers two views of the status word. The plain view has no side effects. The acknowledge view returns the same word, and in the same access it clears a fixed group of cause bits and the whole enable mask. An interrupt handler can therefore take the cause, acknowledge it and mask further interrupts with a single read. A separate read/write register holds the enable mask.

Top module: `irq_status_regs`

## Requirements
- R1: After a synchronous active-high reset, every status bit, every enable bit, `irq` and `reg_rdata` are 0.
- R2: Status bit positions: 1 host error, 2 transmit complete, 3 MAC control frame, 4 receive complete, 5 receive early, 6 interrupt requested, 7 update statistics, 8 link event, 9 transmit DMA complete, 10 receive DMA complete. An event pulse sets its bit at the next clock edge.
- R3: `irq` is the OR over bits 10:1 of status AND enable. Bit 0 of a status read holds the value `irq` had in the read cycle.
- R4: A read of the plain status view (offset 0x4E) loads `reg_rdata` one cycle later with bits 10:1 of status and bit 0 from R3. The read changes neither status nor enable.
- R5: A read of the acknowledge view (offset 0x4A) returns the same word as R4. It clears bits 3, 5, 6, 8, 9 and 10 and the whole enable register at the same edge, so `irq` is 0 in the next cycle. All other status bits are kept.
- R6: A write to offset 0x4E clears each of bits 3, 5, 6 and 8 where the write data holds a 1. Zeros in the data, and ones in any other position, have no effect.
- R7: Host error (bit 1) is set by `ev_bus_abort` and is cleared only by `dma_reset` or by reset. Writes and acknowledge reads leave it set.
- R8: Receive early (bit 5) sets in the cycle in which `rx_head_active` is high and `rx_head_bytes` first exceeds `rx_early_limit`. A `rx_frame_done` pulse clears bit 5 and sets receive complete (bit 4).
- R9: `rx_dma_pop` clears bit 4, `tx_stat_wr` clears bit 2, and `stats_read` clears bit 7.
- R10: Interrupt requested (bit 6) is set by either `ev_host_req` or `ev_countdown_zero`.
- R11: When a set and any clear reach the same bit in the same cycle, the bit ends up set.
- R12: The enable register at offset 0x4C stores write-data bits 10:1 and reads back with bit 0 and bits 15:11 at 0. After an acknowledge read it stays 0 until it is written. Bits 15:11 of every read are 0, and a read of any other offset returns 0.
- R13: If `reg_rd` and `reg_wr` are high in the same cycle, the read is performed and the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| ev_bus_abort | input | 1 | Bus target or master abort |
| dma_reset | input | 1 | DMA reset command; clears host error |
| ev_tx_done | input | 1 | Transmit frame completed or failed |
| tx_stat_wr | input | 1 | Transmit status queue advanced |
| ev_mac_ctrl | input | 1 | MAC control frame received |
| rx_head_active | input | 1 | Head receive frame in progress |
| rx_head_bytes | input | CNT_W | Bytes received of the head frame |
| rx_early_limit | input | CNT_W | Early receive threshold |
| rx_frame_done | input | 1 | Head frame completely received |
| rx_dma_pop | input | 1 | Receive DMA moved a frame out |
| ev_host_req | input | 1 | Host-requested interrupt |
| ev_countdown_zero | input | 1 | Countdown timer expired |
| ev_stats_near_full | input | 1 | A statistics counter is near overflow |
| stats_read | input | 1 | Statistics have been read |
| ev_link_change | input | 1 | Link status change |
| ev_txdma_done | input | 1 | Transmit DMA complete |
| ev_rxdma_done | input | 1 | Receive DMA complete |
| irq | output | 1 | Level interrupt output |

## Verification
The bound checker tests, on every cycle, rules that hold regardless of stimulus. An acknowledge read always leaves `irq` and the enable mask at 0 in the next cycle, and a plain read never changes the mask. Host error stays set unless a DMA reset arrives, a link event always wins over a clear in the same cycle, and bit 0 of a status read always equals the interrupt line. Only the bench's scenarios can show the selective clearing: which bits an acknowledge keeps and which it drops, that zeros and unlisted positions in a write-1 clear do nothing, the receive-early threshold crossing and its hand-over to receive complete, and that a write paired with a read is ignored. Those scenarios compare every cycle against a model of the register set built from the requirements.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int NUM_EV = 11;

  localparam int B_IRQ        = 0;
  localparam int B_HOST_ERR   = 1;
  localparam int B_TX_DONE    = 2;
  localparam int B_MAC_CTRL   = 3;
  localparam int B_RX_DONE    = 4;
  localparam int B_RX_EARLY   = 5;
  localparam int B_REQ        = 6;
  localparam int B_STATS      = 7;
  localparam int B_LINK       = 8;
  localparam int B_TXDMA      = 9;
  localparam int B_RXDMA      = 10;

  // bits the host may clear with a write of 1
  localparam logic [NUM_EV-1:0] W1C_MASK =
    (NUM_EV'(1) << B_MAC_CTRL) | (NUM_EV'(1) << B_RX_EARLY) |
    (NUM_EV'(1) << B_REQ) | (NUM_EV'(1) << B_LINK);
  // bits dropped by an acknowledge read
  localparam logic [NUM_EV-1:0] ACK_MASK =
    W1C_MASK | (NUM_EV'(1) << B_TXDMA) | (NUM_EV'(1) << B_RXDMA);
  // bits that carry an enable
  localparam logic [NUM_EV-1:0] EN_MASK = ~NUM_EV'(1);
endpackage

// File: rtl/irq_bit_latch.sv
module irq_bit_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;   // set has priority over clear
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_rx_early_det.sv
module irq_rx_early_det #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             head_active,
  input  logic [CNT_W-1:0] head_bytes,
  input  logic [CNT_W-1:0] limit,
  input  logic             frame_done,
  output logic             early_set_o
);
  logic above, above_q;

  assign above = head_active && (head_bytes > limit);

  always_ff @(posedge clk) begin
    if (rst) above_q <= 1'b0;
    else     above_q <= above;
  end

  // one pulse on the crossing; a finishing frame does not raise it
  assign early_set_o = above && !above_q && !frame_done;
endmodule

// File: rtl/irq_host_decode.sv
module irq_host_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ACK_OFS    = 'h4A,
  parameter logic [ADDR_W-1:0] ENABLE_OFS = 'h4C,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 'h4E
) (
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  output logic              rd_status,
  output logic              rd_ack,
  output logic              rd_enable,
  output logic              wr_status,
  output logic              wr_enable
);
  logic wr_ok;

  assign wr_ok     = reg_wr && !reg_rd;   // a read in the same cycle wins
  assign rd_status = reg_rd && (reg_addr == STATUS_OFS);
  assign rd_ack    = reg_rd && (reg_addr == ACK_OFS);
  assign rd_enable = reg_rd && (reg_addr == ENABLE_OFS);
  assign wr_status = wr_ok && (reg_addr == STATUS_OFS);
  assign wr_enable = wr_ok && (reg_addr == ENABLE_OFS);
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter logic [ADDR_W-1:0] ACK_OFS    = 'h4A,
  parameter logic [ADDR_W-1:0] ENABLE_OFS = 'h4C,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 'h4E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_bus_abort,
  input  logic              dma_reset,
  input  logic              ev_tx_done,
  input  logic              tx_stat_wr,
  input  logic              ev_mac_ctrl,
  input  logic              rx_head_active,
  input  logic [CNT_W-1:0]  rx_head_bytes,
  input  logic [CNT_W-1:0]  rx_early_limit,
  input  logic              rx_frame_done,
  input  logic              rx_dma_pop,
  input  logic              ev_host_req,
  input  logic              ev_countdown_zero,
  input  logic              ev_stats_near_full,
  input  logic              stats_read,
  input  logic              ev_link_change,
  input  logic              ev_txdma_done,
  input  logic              ev_rxdma_done,
  output logic              irq
);
  localparam int PAD_W = DATA_W - NUM_EV;

  logic rd_status, rd_ack, rd_enable, wr_status, wr_enable;
  logic early_set;
  logic [NUM_EV-1:0] ev_set, ev_clr, status_q, enable_q, status_view;

  irq_host_decode #(
    .ADDR_W(ADDR_W), .ACK_OFS(ACK_OFS),
    .ENABLE_OFS(ENABLE_OFS), .STATUS_OFS(STATUS_OFS)
  ) u_dec (
    .reg_addr (reg_addr),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .rd_status(rd_status),
    .rd_ack   (rd_ack),
    .rd_enable(rd_enable),
    .wr_status(wr_status),
    .wr_enable(wr_enable)
  );

  irq_rx_early_det #(.CNT_W(CNT_W)) u_early (
    .clk        (clk),
    .rst        (rst),
    .head_active(rx_head_active),
    .head_bytes (rx_head_bytes),
    .limit      (rx_early_limit),
    .frame_done (rx_frame_done),
    .early_set_o(early_set)
  );

  always_comb begin
    ev_set               = '0;
    ev_set[B_HOST_ERR]   = ev_bus_abort;
    ev_set[B_TX_DONE]    = ev_tx_done;
    ev_set[B_MAC_CTRL]   = ev_mac_ctrl;
    ev_set[B_RX_DONE]    = rx_frame_done;
    ev_set[B_RX_EARLY]   = early_set;
    ev_set[B_REQ]        = ev_host_req | ev_countdown_zero;
    ev_set[B_STATS]      = ev_stats_near_full;
    ev_set[B_LINK]       = ev_link_change;
    ev_set[B_TXDMA]      = ev_txdma_done;
    ev_set[B_RXDMA]      = ev_rxdma_done;

    ev_clr               = '0;
    ev_clr[B_HOST_ERR]   = dma_reset;
    ev_clr[B_TX_DONE]    = tx_stat_wr;
    ev_clr[B_RX_DONE]    = rx_dma_pop;
    ev_clr[B_RX_EARLY]   = rx_frame_done;
    ev_clr[B_STATS]      = stats_read;
    if (wr_status) ev_clr = ev_clr | (reg_wdata[NUM_EV-1:0] & W1C_MASK);
    if (rd_ack)    ev_clr = ev_clr | ACK_MASK;
  end

  irq_bit_latch #(.WIDTH(NUM_EV)) u_latch (
    .clk  (clk),
    .rst  (rst),
    .set_i(ev_set),
    .clr_i(ev_clr),
    .q_o  (status_q)
  );

  always_ff @(posedge clk) begin
    if (rst)            enable_q <= '0;
    else if (rd_ack)    enable_q <= '0;
    else if (wr_enable) enable_q <= reg_wdata[NUM_EV-1:0] & EN_MASK;
  end

  assign irq = |(status_q & enable_q);

  always_comb begin
    status_view        = status_q;
    status_view[B_IRQ] = irq;
  end

  always_ff @(posedge clk) begin
    if (rst)                        reg_rdata <= '0;
    else if (rd_status || rd_ack)   reg_rdata <= {{PAD_W{1'b0}}, status_view};
    else if (rd_enable)             reg_rdata <= {{PAD_W{1'b0}}, enable_q};
    else if (reg_rd)                reg_rdata <= '0;
  end
endmodule

// File: rtl/irq_regs_checker.sv
module irq_regs_checker
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] ACK_OFS    = 'h4A,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 'h4E
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq,
  input logic              dma_reset,
  input logic              ev_link_change,
  input logic [NUM_EV-1:0] status_q,
  input logic [NUM_EV-1:0] enable_q
);
  assert_ack_masks_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ACK_OFS) |=> (!irq && enable_q == '0));

  assert_plain_read_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == STATUS_OFS) |=> (enable_q == $past(enable_q)));

  assert_read_bit0_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (reg_addr == STATUS_OFS || reg_addr == ACK_OFS))
      |=> (reg_rdata[0] == $past(irq)));

  assert_host_err_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (status_q[B_HOST_ERR] && !dma_reset) |=> status_q[B_HOST_ERR]);

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
    ev_link_change |=> status_q[B_LINK]);

  assert_upper_zero_R12: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:NUM_EV] == '0);
endmodule

bind irq_status_regs irq_regs_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACK_OFS(ACK_OFS), .STATUS_OFS(STATUS_OFS)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .reg_addr      (reg_addr),
  .reg_rd        (reg_rd),
  .reg_rdata     (reg_rdata),
  .irq           (irq),
  .dma_reset     (dma_reset),
  .ev_link_change(ev_link_change),
  .status_q      (status_q),
  .enable_q      (enable_q)
);

// File: tb/sim_irq_status_regs.sv
`timescale 1ns/1ps
module sim_irq_status_regs;
  localparam logic [7:0] A_ACK = 8'h4A, A_EN = 8'h4C, A_ST = 8'h4E;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_rd = 0, reg_wr = 0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic ev_bus_abort = 0, dma_reset = 0, ev_tx_done = 0, tx_stat_wr = 0;
  logic ev_mac_ctrl = 0, rx_head_active = 0, rx_frame_done = 0, rx_dma_pop = 0;
  logic [15:0] rx_head_bytes = '0, rx_early_limit = 16'd100;
  logic ev_host_req = 0, ev_countdown_zero = 0, ev_stats_near_full = 0;
  logic stats_read = 0, ev_link_change = 0, ev_txdma_done = 0, ev_rxdma_done = 0;
  logic irq;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [10:0] m_st = '0, m_en = '0;
  logic        m_above = 0;
  logic [15:0] m_rdata = '0;

  always #5 clk = ~clk;

  irq_status_regs u0 (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // next-state model of the register set, derived from R2..R13
  task automatic tick();
    logic [10:0] s, c;
    logic above, irq_now, wr_ok;
    above   = rx_head_active && (rx_head_bytes > rx_early_limit);
    irq_now = |(m_st & m_en);
    wr_ok   = reg_wr && !reg_rd;
    s = '0; c = '0;
    s[1] = ev_bus_abort;  s[2] = ev_tx_done;  s[3] = ev_mac_ctrl;
    s[4] = rx_frame_done; s[5] = above && !m_above && !rx_frame_done;
    s[6] = ev_host_req | ev_countdown_zero;   s[7] = ev_stats_near_full;
    s[8] = ev_link_change; s[9] = ev_txdma_done; s[10] = ev_rxdma_done;
    c[1] = dma_reset; c[2] = tx_stat_wr; c[4] = rx_dma_pop;
    c[5] = rx_frame_done; c[7] = stats_read;
    if (wr_ok && reg_addr == A_ST) c = c | (reg_wdata[10:0] & 11'h168);
    if (reg_rd && reg_addr == A_ACK) c = c | 11'h768;
    @(posedge clk);
    #1;
    if (reg_rd) begin
      if (reg_addr == A_ST || reg_addr == A_ACK) m_rdata = {5'b0, m_st[10:1], irq_now};
      else if (reg_addr == A_EN) m_rdata = {5'b0, m_en};
      else m_rdata = '0;
    end
    if (reg_rd && reg_addr == A_ACK) m_en = '0;
    else if (wr_ok && reg_addr == A_EN) m_en = reg_wdata[10:0] & 11'h7FE;
    m_st = (m_st & ~c) | s;
    m_above = above;
    check("R3 irq", {15'b0, irq}, {15'b0, |(m_st & m_en)});
    check("R4 rdata", reg_rdata, m_rdata);
    @(negedge clk);
    {ev_bus_abort, dma_reset, ev_tx_done, tx_stat_wr, ev_mac_ctrl, rx_frame_done,
     rx_dma_pop, ev_host_req, ev_countdown_zero, ev_stats_near_full, stats_read,
     ev_link_change, ev_txdma_done, ev_rxdma_done, reg_rd, reg_wr} = '0;
  endtask

  task automatic rd(logic [7:0] a);
    reg_addr = a; reg_rd = 1; tick();
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; tick();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check("R1 irq after reset", {15'b0, irq}, 16'h0);
    check("R1 rdata after reset", reg_rdata, 16'h0);
    rd(A_ST);  check("R1 status", reg_rdata, 16'h0000);

    wr(A_EN, 16'hFFFF); rd(A_EN); check("R12 enable readback", reg_rdata, 16'h07FE);
    rd(8'h10); check("R12 unmapped read", reg_rdata, 16'h0000);

    ev_link_change = 1; tick();
    check("R2 link sets irq", {15'b0, irq}, 16'h1);
    rd(A_ST); check("R2 link bit", reg_rdata, 16'h0101);
    wr(A_ST, 16'h0000); rd(A_ST); check("R6 zero write", reg_rdata, 16'h0101);
    wr(A_ST, 16'hFEFF); rd(A_ST); check("R6 other positions", reg_rdata, 16'h0101);
    wr(A_ST, 16'h0100); rd(A_ST); check("R6 write one clears", reg_rdata, 16'h0000);

    ev_bus_abort = 1; tick();
    rd(A_ACK); check("R5 ack returns status", reg_rdata, 16'h0003);
    check("R5 irq low after ack", {15'b0, irq}, 16'h0);
    rd(A_ST);  check("R7 host error survives ack", reg_rdata, 16'h0002);
    rd(A_EN);  check("R12 enable held zero", reg_rdata, 16'h0000);
    wr(A_ST, 16'hFFFF); rd(A_ST); check("R7 write ignored", reg_rdata, 16'h0002);
    dma_reset = 1; tick(); rd(A_ST); check("R7 dma reset clears", reg_rdata, 16'h0000);

    wr(A_EN, 16'h07FE);
    rx_head_active = 1; rx_head_bytes = 16'd50; tick();
    rd(A_ST); check("R8 below limit", reg_rdata, 16'h0000);
    rx_head_bytes = 16'd101; tick();
    rd(A_ST); check("R8 early on crossing", reg_rdata, 16'h0021);
    rx_frame_done = 1; rx_head_active = 0; tick();
    rd(A_ST); check("R8 done hands over", reg_rdata, 16'h0011);
    rx_dma_pop = 1; tick(); rd(A_ST); check("R9 rx pop clears", reg_rdata, 16'h0000);
    ev_tx_done = 1; tick(); rd(A_ST); check("R9 tx set", reg_rdata, 16'h0005);
    tx_stat_wr = 1; tick(); rd(A_ST); check("R9 tx status clears", reg_rdata, 16'h0000);
    ev_stats_near_full = 1; tick(); rd(A_ST); check("R9 stats set", reg_rdata, 16'h0081);
    stats_read = 1; tick(); rd(A_ST); check("R9 stats clears", reg_rdata, 16'h0000);

    ev_host_req = 1; tick(); rd(A_ST); check("R10 host request", reg_rdata, 16'h0041);
    wr(A_ST, 16'h0040);
    ev_countdown_zero = 1; tick(); rd(A_ST); check("R10 countdown", reg_rdata, 16'h0041);
    wr(A_ST, 16'h0040);

    ev_link_change = 1; reg_addr = A_ST; reg_wdata = 16'h0100; reg_wr = 1; tick();
    rd(A_ST); check("R11 set beats clear", reg_rdata, 16'h0101);
    wr(A_ST, 16'h0100);

    ev_txdma_done = 1; ev_rxdma_done = 1; ev_mac_ctrl = 1; ev_tx_done = 1;
    ev_stats_near_full = 1; tick();
    rd(A_ACK); check("R5 ack value", reg_rdata, 16'h068D);
    check("R5 irq dropped", {15'b0, irq}, 16'h0);
    rd(A_ST);  check("R5 kept bits", reg_rdata, 16'h0084);
    rd(A_EN);  check("R5 enable cleared", reg_rdata, 16'h0000);

    reg_addr = A_EN; reg_wdata = 16'hFFFF; reg_rd = 1; reg_wr = 1; tick();
    check("R13 read performed", reg_rdata, 16'h0000);
    rd(A_EN); check("R13 write ignored", reg_rdata, 16'h0000);
    tx_stat_wr = 1; stats_read = 1; tick();

    for (int i = 0; i < 3000; i++) begin
      ev_bus_abort       = ($urandom_range(31) == 0);
      dma_reset          = ($urandom_range(15) == 0);
      ev_tx_done         = ($urandom_range(7) == 0);
      tx_stat_wr         = ($urandom_range(7) == 0);
      ev_mac_ctrl        = ($urandom_range(7) == 0);
      rx_frame_done      = ($urandom_range(15) == 0);
      rx_dma_pop         = ($urandom_range(7) == 0);
      ev_host_req        = ($urandom_range(15) == 0);
      ev_countdown_zero  = ($urandom_range(15) == 0);
      ev_stats_near_full = ($urandom_range(15) == 0);
      stats_read         = ($urandom_range(7) == 0);
      ev_link_change     = ($urandom_range(7) == 0);
      ev_txdma_done      = ($urandom_range(7) == 0);
      ev_rxdma_done      = ($urandom_range(7) == 0);
      rx_head_active     = ($urandom_range(3) != 0);
      rx_head_bytes      = 16'($urandom_range(200));
      case ($urandom_range(3))
        0: reg_addr = A_ST;
        1: reg_addr = A_ACK;
        2: reg_addr = A_EN;
        default: reg_addr = 8'($urandom_range(255));
      endcase
      reg_rd    = ($urandom_range(2) == 0);
      reg_wr    = ($urandom_range(2) == 0);
      reg_wdata = 16'($urandom());
      tick();
    end
    finish_run();
  end
endmodule